// File: doc/BRIEF.md
# Rectangular copy blit engine

The engine copies a rectangle of pixels from a source surface into a destination surface. Both surfaces are linear and word-addressed through a single memory port. For every destination pixel it reads the source pixel, reads the destination pixel and writes back a combination of the two. An 8-bit raster-operation code selects that combination separately for each bit. A pixel is 1, 2 or 4 bytes wide. For 4-byte pixels, two enables choose whether the colour bytes, the alpha byte, or both may change.

Software loads the command inputs and pulses `start_i`. The engine samples every command input on that edge and checks that the command is legal. It then walks the destination rectangle row by row. The source row pointer advances by a signed pitch, so a negative source pitch reads the image bottom-up and flips it vertically. Completion is a one-cycle `done_o` pulse. An illegal command raises `err_o` instead of starting work.

Top module: `copy_blit`

## Requirements
- R1: The control word is decoded as follows. Bits 15:0 are the destination pitch in bytes. Bits 23:16 are the raster-op code. Bits 25:24 are the depth code (0 = 1 byte, 1 = 2 bytes, 3 = 4 bytes, 2 = illegal). Bit 26 is the alpha write enable and bit 27 is the colour write enable.
- R2: Each corner word holds y in bits 31:16 and x in bits 15:0, both 16-bit signed. The engine writes exactly the pixels with x1 <= x < x2 and y1 <= y < y2, and no other bytes.
- R3: A legal command with x2 <= x1 or y2 <= y1 produces `done_o` on the edge that samples `start_i`. It makes no memory access and leaves `err_o` low.
- R4: Each result bit is bit 4+2s+d of the raster-op code, where s is the source bit and d is the destination bit. So 0xCC copies the source, 0x66 gives source XOR destination, 0x00 clears, 0xFF sets, 0xAA keeps the destination and 0x55 inverts it.
- R5: The destination pixel (x,y) lives at dst_base + y*dst_pitch + x*bytes. The source pixel for rectangle offset (i,j) lives at src_base + (sy+j)*src_pitch + (sx+i)*bytes, with src_pitch signed. A negative src_pitch therefore steps source rows downward in memory.
- R6: For 4-byte pixels, bit 27 gates byte lanes 0 to 2 and bit 26 gates byte lane 3 of each pixel. For 1- and 2-byte pixels both bits are ignored and every byte of the pixel is written.
- R7: A command is illegal if any of the following holds:
  - the depth code is 2;
  - a pitch is not a multiple of 4;
  - the destination pitch is 32768 or more;
  - the source pitch is -32768;
  - any corner coordinate is negative;
  - either base is not word-aligned.

  An illegal command raises `err_o` until the next start and pulses `done_o` on the sampling edge. `busy_o` stays low and no memory access is made.
- R8: After reset, `busy_o`, `done_o`, `err_o` and `mem_req_o` are low. `busy_o` is high from the sampling edge until `done_o`. `done_o` lasts one cycle with `busy_o` low. `start_i` and all command inputs are ignored while busy.
- R9: Each pixel takes three consecutive request cycles: a source read, then a destination read, then a write. Read data is taken from `mem_rdata_i` in the cycle after the read request. Addresses are word-aligned and byte k of a word sits in lane k. An N-pixel command raises `done_o` 3N edges after the sampling edge.
- R10: Pixels are processed in ascending x within a row and rows in ascending y. An overlapping copy therefore sees the results of earlier pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start strobe |
| ctl_i | input | 28 | Control word: pitch, raster op, depth, write enables |
| dst_tl_i | input | 32 | Destination start corner {y1,x1} |
| dst_br_i | input | 32 | Destination exclusive end corner {y2,x2} |
| src_tl_i | input | 32 | Source start corner {sy,sx} |
| src_pitch_i | input | 16 | Signed source pitch in bytes |
| dst_base_i | input | AW | Destination surface base byte address |
| src_base_i | input | AW | Source surface base byte address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command was illegal |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read |

## Verification
Most internal faults in this engine show up at the memory port within one pixel time of three cycles.
- A row pointer or pitch step that goes wrong puts the first write of the next row at a wrong address. A full-memory comparison after the command catches it.
- A wrong latched source word, lane shift or raster-op index corrupts the data of that same pixel's write.
- A sequencing fault changes the number of cycles before `done_o`, which the bench counts exactly.
- A legality or empty-rectangle decode fault shows up in `err_o`, or as writes during a command that must leave memory untouched.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int WORD_W        = 32;
    localparam int LANES         = WORD_W / 8;
    localparam int CRD_W         = 16;
    localparam int CTL_W         = 28;
    localparam int CTL_PITCH_LSB = 0;
    localparam int CTL_ROP_LSB   = 16;
    localparam int CTL_DEPTH_LSB = 24;
    localparam int CTL_WA_BIT    = 26;
    localparam int CTL_WRGB_BIT  = 27;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_SRC = 2'd1,
        ST_RD_DST = 2'd2,
        ST_WRITE  = 2'd3
    } blit_state_e;

    typedef struct packed {
        logic [7:0] rop;
        logic [1:0] bsh;   // log2 of bytes per pixel
        logic       wa;
        logic       wrgb;
    } pix_mode_t;

    function automatic logic depth_ok(input logic [1:0] code);
        return code != 2'd2;
    endfunction

    function automatic logic [1:0] depth_shift(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd3:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/blit_cmd_check.sv
module blit_cmd_check
    import blit_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [31:0]      dtl_i,
    input  logic [31:0]      dbr_i,
    input  logic [31:0]      stl_i,
    input  logic [CRD_W-1:0] spitch_i,
    input  logic [1:0]       dbase_lo_i,
    input  logic [1:0]       sbase_lo_i,
    output pix_mode_t        mode_o,
    output logic             legal_o,
    output logic             empty_o,
    output logic [CRD_W-1:0] ncols_o,
    output logic [CRD_W-1:0] nrows_o
);

    logic [CRD_W-1:0] x1, y1, x2, y2;
    logic [CRD_W-1:0] dpitch;
    logic [1:0]       dcode;
    logic             neg_crd;
    logic             pitch_bad;

    assign x1     = dtl_i[CRD_W-1:0];
    assign y1     = dtl_i[31:CRD_W];
    assign x2     = dbr_i[CRD_W-1:0];
    assign y2     = dbr_i[31:CRD_W];
    assign dpitch = ctl_i[CTL_PITCH_LSB +: CRD_W];
    assign dcode  = ctl_i[CTL_DEPTH_LSB +: 2];

    // Any sign bit set in any of the six coordinates is illegal
    assign neg_crd = dtl_i[15] | dtl_i[31] | dbr_i[15] | dbr_i[31]
                   | stl_i[15] | stl_i[31];

    // Pitches: dword multiples, magnitude below 32768
    assign pitch_bad = (dpitch[1:0] != 2'b00) | dpitch[CRD_W-1]
                     | (spitch_i[1:0] != 2'b00)
                     | (spitch_i == {1'b1, {(CRD_W-1){1'b0}}});

    assign legal_o = depth_ok(dcode) & !pitch_bad & !neg_crd
                   & (dbase_lo_i == 2'b00) & (sbase_lo_i == 2'b00);

    assign empty_o = (x2 <= x1) | (y2 <= y1);
    assign ncols_o = x2 - x1;
    assign nrows_o = y2 - y1;

    always_comb begin
        mode_o.rop  = ctl_i[CTL_ROP_LSB +: 8];
        mode_o.bsh  = depth_shift(dcode);
        mode_o.wa   = ctl_i[CTL_WA_BIT];
        mode_o.wrgb = ctl_i[CTL_WRGB_BIT];
    end

endmodule

// File: rtl/blit_addr_start.sv
module blit_addr_start
    import blit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]       bsh_i,
    input  logic [CRD_W-1:0] dx_i,
    input  logic [CRD_W-1:0] dy_i,
    input  logic [CRD_W-1:0] sx_i,
    input  logic [CRD_W-1:0] sy_i,
    input  logic [CRD_W-1:0] dpitch_i,
    input  logic [CRD_W-1:0] spitch_i,
    input  logic [AW-1:0]    dbase_i,
    input  logic [AW-1:0]    sbase_i,
    output logic [AW-1:0]    src_row0_o,
    output logic [AW-1:0]    dst_row0_o,
    output logic [AW-1:0]    src_step_o,
    output logic [AW-1:0]    dst_step_o
);

    localparam int PAD = AW - CRD_W;

    logic [AW-1:0] sp_ext, dp_ext;
    logic [AW-1:0] sy_ext, dy_ext, sx_ext, dx_ext;
    logic [AW-1:0] s_rows, d_rows;

    // Source pitch is signed; the truncated product keeps two's complement bits
    assign sp_ext = {{PAD{spitch_i[CRD_W-1]}}, spitch_i};
    assign dp_ext = {{PAD{1'b0}}, dpitch_i};
    assign sy_ext = {{PAD{1'b0}}, sy_i};
    assign dy_ext = {{PAD{1'b0}}, dy_i};
    assign sx_ext = {{PAD{1'b0}}, sx_i};
    assign dx_ext = {{PAD{1'b0}}, dx_i};

    assign s_rows = sy_ext * sp_ext;
    assign d_rows = dy_ext * dp_ext;

    assign src_row0_o = sbase_i + s_rows + (sx_ext << bsh_i);
    assign dst_row0_o = dbase_i + d_rows + (dx_ext << bsh_i);
    assign src_step_o = sp_ext;
    assign dst_step_o = dp_ext;

endmodule

// File: rtl/blit_rop_lane.sv
module blit_rop_lane
    import blit_pkg::*;
(
    input  pix_mode_t         mode_i,
    input  logic [1:0]        src_lane_i,
    input  logic [1:0]        dst_lane_i,
    input  logic [WORD_W-1:0] src_word_i,
    input  logic [WORD_W-1:0] dst_word_i,
    output logic [WORD_W-1:0] wdata_o,
    output logic [LANES-1:0]  be_o
);

    logic [WORD_W-1:0] src_al;
    logic [LANES-1:0]  pix_mask;

    // Move the source pixel into the byte lanes of the destination pixel
    assign src_al = (src_word_i >> {src_lane_i, 3'b000}) << {dst_lane_i, 3'b000};

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            assign wdata_o[b] = mode_i.rop[{1'b1, src_al[b], dst_word_i[b]}];
        end
    endgenerate

    always_comb begin
        case (mode_i.bsh)
            2'd0:    pix_mask = 4'b0001;
            2'd1:    pix_mask = 4'b0011;
            default: pix_mask = {mode_i.wa, mode_i.wrgb, mode_i.wrgb, mode_i.wrgb};
        endcase
    end

    assign be_o = pix_mask << dst_lane_i;

endmodule

// File: rtl/copy_blit.sv
module copy_blit
    import blit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [31:0]       dst_tl_i,
    input  logic [31:0]       dst_br_i,
    input  logic [31:0]       src_tl_i,
    input  logic [CRD_W-1:0]  src_pitch_i,
    input  logic [AW-1:0]     dst_base_i,
    input  logic [AW-1:0]     src_base_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [LANES-1:0]  mem_be_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);

    typedef struct packed {
        blit_state_e       st;
        pix_mode_t         mode;
        logic [AW-1:0]     src_row;
        logic [AW-1:0]     dst_row;
        logic [AW-1:0]     src_step;
        logic [AW-1:0]     dst_step;
        logic [AW-1:0]     xoff;
        logic [CRD_W-1:0]  ncols;
        logic [CRD_W-1:0]  nrows;
        logic [CRD_W-1:0]  col;
        logic [CRD_W-1:0]  row;
        logic [WORD_W-1:0] src_word;
        logic              done;
        logic              err;
    } blit_regs_t;

    blit_regs_t r_d, r_q;

    pix_mode_t        cmd_mode;
    logic             cmd_legal, cmd_empty;
    logic [CRD_W-1:0] cmd_ncols, cmd_nrows;
    logic [AW-1:0]    src_row0, dst_row0, src_step0, dst_step0;
    logic [AW-1:0]    src_addr, dst_addr;
    logic [WORD_W-1:0] lane_wdata;
    logic [LANES-1:0]  lane_be;
    logic             last_col, last_row;

    blit_cmd_check u_check (
        .ctl_i      (ctl_i),
        .dtl_i      (dst_tl_i),
        .dbr_i      (dst_br_i),
        .stl_i      (src_tl_i),
        .spitch_i   (src_pitch_i),
        .dbase_lo_i (dst_base_i[1:0]),
        .sbase_lo_i (src_base_i[1:0]),
        .mode_o     (cmd_mode),
        .legal_o    (cmd_legal),
        .empty_o    (cmd_empty),
        .ncols_o    (cmd_ncols),
        .nrows_o    (cmd_nrows)
    );

    blit_addr_start #(.AW(AW)) u_start (
        .bsh_i      (cmd_mode.bsh),
        .dx_i       (dst_tl_i[CRD_W-1:0]),
        .dy_i       (dst_tl_i[31:CRD_W]),
        .sx_i       (src_tl_i[CRD_W-1:0]),
        .sy_i       (src_tl_i[31:CRD_W]),
        .dpitch_i   (ctl_i[CTL_PITCH_LSB +: CRD_W]),
        .spitch_i   (src_pitch_i),
        .dbase_i    (dst_base_i),
        .sbase_i    (src_base_i),
        .src_row0_o (src_row0),
        .dst_row0_o (dst_row0),
        .src_step_o (src_step0),
        .dst_step_o (dst_step0)
    );

    assign src_addr = r_q.src_row + r_q.xoff;
    assign dst_addr = r_q.dst_row + r_q.xoff;

    blit_rop_lane u_lane (
        .mode_i     (r_q.mode),
        .src_lane_i (src_addr[1:0]),
        .dst_lane_i (dst_addr[1:0]),
        .src_word_i (r_q.src_word),
        .dst_word_i (mem_rdata_i),
        .wdata_o    (lane_wdata),
        .be_o       (lane_be)
    );

    assign last_col = (r_q.col == r_q.ncols - 1'b1);
    assign last_row = (r_q.row == r_q.nrows - 1'b1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.err = !cmd_legal;
                    if (!cmd_legal || cmd_empty) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st       = ST_RD_SRC;
                        r_d.mode     = cmd_mode;
                        r_d.src_row  = src_row0;
                        r_d.dst_row  = dst_row0;
                        r_d.src_step = src_step0;
                        r_d.dst_step = dst_step0;
                        r_d.xoff     = '0;
                        r_d.ncols    = cmd_ncols;
                        r_d.nrows    = cmd_nrows;
                        r_d.col      = '0;
                        r_d.row      = '0;
                    end
                end
            end
            ST_RD_SRC: begin
                r_d.st = ST_RD_DST;
            end
            ST_RD_DST: begin
                r_d.src_word = mem_rdata_i;
                r_d.st       = ST_WRITE;
            end
            ST_WRITE: begin
                if (!last_col) begin
                    r_d.col  = r_q.col + 1'b1;
                    r_d.xoff = r_q.xoff + ({{(AW-1){1'b0}}, 1'b1} << r_q.mode.bsh);
                    r_d.st   = ST_RD_SRC;
                end else begin
                    r_d.col  = '0;
                    r_d.xoff = '0;
                    if (last_row) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.row     = r_q.row + 1'b1;
                        r_d.src_row = r_q.src_row + r_q.src_step;
                        r_d.dst_row = r_q.dst_row + r_q.dst_step;
                        r_d.st      = ST_RD_SRC;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign mem_req_o   = (r_q.st != ST_IDLE);
    assign mem_we_o    = (r_q.st == ST_WRITE);
    assign mem_addr_o  = (r_q.st == ST_RD_SRC) ? {src_addr[AW-1:2], 2'b00}
                                               : {dst_addr[AW-1:2], 2'b00};
    assign mem_wdata_o = lane_wdata;
    assign mem_be_o    = (r_q.st == ST_WRITE) ? lane_be : '0;

    AST_ERR_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o); // R7

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R8

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_req_o && !mem_we_o)); // R9

    AST_BE_WITHIN_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($countones(mem_be_o) <= (1 << r_q.mode.bsh))); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !err_o); // R8

endmodule

// File: tb/copy_blit_test.sv
`timescale 1ns/1ps
module copy_blit_test;

    localparam int AW = 32;
    localparam int NV = 19;
    localparam int MW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [27:0] ctl_i = '0;
    logic [31:0] dst_tl_i = '0, dst_br_i = '0, src_tl_i = '0;
    logic [15:0] src_pitch_i = '0;
    logic [31:0] dst_base_i = '0, src_base_i = '0;
    logic        busy_o, done_o, err_o, mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o;

    always #10 clk = ~clk;

    copy_blit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctl_i(ctl_i),
        .dst_tl_i(dst_tl_i), .dst_br_i(dst_br_i), .src_tl_i(src_tl_i),
        .src_pitch_i(src_pitch_i), .dst_base_i(dst_base_i), .src_base_i(src_base_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i)
    );

    logic [31:0] mem     [0:MW-1];
    logic [31:0] ref_mem [0:MW-1];

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MW; i++) mem[i] <= pat(i);
        end else begin
            if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[11:2]];
            if (mem_we_o)
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[11:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end
    end

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] dtl;
        logic [31:0] dbr;
        logic [31:0] stl;
        logic [15:0] sp;
        logic [31:0] db;
        logic [31:0] sb;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h00CC0040, 32'h00010002, 32'h00040006, 32'h00000001, 16'h0040, 32'h800, 32'h000},
        '{32'h01660040, 32'h00010002, 32'h00030005, 32'h00020001, 16'h0040, 32'h800, 32'h000},
        '{32'h0FCC0040, 32'h00010002, 32'h00040006, 32'h00000001, 16'h0040, 32'h800, 32'h000},
        '{32'h0BCC0040, 32'h00020001, 32'h00040004, 32'h00010003, 16'h0040, 32'h800, 32'h000},
        '{32'h07CC0040, 32'h00020001, 32'h00040004, 32'h00010003, 16'h0040, 32'h800, 32'h100},
        '{32'h00CC0040, 32'h00010002, 32'h00040006, 32'h00010001, 16'hFFC0, 32'h800, 32'h400},
        '{32'h01000040, 32'h00000000, 32'h00020003, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h00FF0040, 32'h00000005, 32'h00030009, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h0FAA0040, 32'h00010000, 32'h00030003, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h0F550040, 32'h00010000, 32'h00030003, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h00CC0040, 32'h00010004, 32'h00050004, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h00CC0040, 32'h00030001, 32'h00020006, 32'h00000000, 16'h0040, 32'h800, 32'h000},
        '{32'h02CC0040, 32'h00010002, 32'h00040006, 32'h00000001, 16'h0040, 32'h800, 32'h000},
        '{32'h00CC003E, 32'h00010002, 32'h00040006, 32'h00000001, 16'h0040, 32'h800, 32'h000},
        '{32'h00CC0040, 32'hFFFF0001, 32'h00040006, 32'h00000001, 16'h0040, 32'h800, 32'h000},
        '{32'h00CC0040, 32'h00010002, 32'h00040006, 32'h00000001, 16'h8000, 32'h800, 32'h000},
        '{32'h00CC0040, 32'h00010002, 32'h00040006, 32'h00000001, 16'h0040, 32'h802, 32'h000},
        '{32'h00CC0040, 32'h00010003, 32'h00020007, 32'h00010002, 16'h0040, 32'h800, 32'h800},
        '{32'h01CC0080, 32'h00010001, 32'h00030004, 32'h00000000, 16'h0040, 32'h800, 32'h000}
    };

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // R7: legality from the requirement list
    function automatic bit ref_legal(vec_t v);
        bit ok = 1'b1;
        if (v.ctl[25:24] == 2'd2) ok = 0;
        if (v.ctl[1:0] != 0 || v.ctl[15]) ok = 0;
        if (v.sp[1:0] != 0 || v.sp == 16'h8000) ok = 0;
        if (v.dtl[15] || v.dtl[31] || v.dbr[15] || v.dbr[31] || v.stl[15] || v.stl[31]) ok = 0;
        if (v.db[1:0] != 0 || v.sb[1:0] != 0) ok = 0;
        return ok;
    endfunction

    function automatic int ref_pixels(vec_t v);
        int w = int'(v.dbr[15:0]) - int'(v.dtl[15:0]);
        int h = int'(v.dbr[31:16]) - int'(v.dtl[31:16]);
        if (!ref_legal(v) || w <= 0 || h <= 0) return 0;
        return w * h;
    endfunction

    function automatic int rb(int a);
        return int'((ref_mem[a >> 2] >> (8 * (a % 4))) & 32'hFF);
    endfunction

    task automatic wb(int a, int val);
        ref_mem[a >> 2][8 * (a % 4) +: 8] = val[7:0];
    endtask

    // R2 R4 R5 R6 R10 reference model, pixel by pixel in row-major order
    task automatic ref_apply(vec_t v);
        int bsh, bpp, x1, y1, x2, y2, sx, sy, sp, dp, sa, da, s, d, r;
        if (ref_pixels(v) == 0) return;
        bsh = (v.ctl[25:24] == 2'd3) ? 2 : int'(v.ctl[25:24]);
        bpp = 1 << bsh;
        x1 = int'(v.dtl[15:0]); y1 = int'(v.dtl[31:16]);
        x2 = int'(v.dbr[15:0]); y2 = int'(v.dbr[31:16]);
        sx = int'(v.stl[15:0]); sy = int'(v.stl[31:16]);
        sp = int'($signed(v.sp)); dp = int'(v.ctl[15:0]);
        for (int y = y1; y < y2; y++)
            for (int x = x1; x < x2; x++) begin
                sa = int'(v.sb) + (sy + y - y1) * sp + (sx + x - x1) * bpp;
                da = int'(v.db) + y * dp + x * bpp;
                for (int k = 0; k < bpp; k++) begin
                    if (bpp == 4 && ((k == 3 && !v.ctl[26]) || (k < 3 && !v.ctl[27]))) continue;
                    s = rb(sa + k); d = rb(da + k); r = 0;
                    for (int b = 0; b < 8; b++)
                        if (v.ctl[16 + 4 + 2 * ((s >> b) & 1) + ((d >> b) & 1)]) r |= (1 << b);
                    wb(da + k, r);
                end
            end
    endtask

    task automatic compare_mem(input string tag);
        int bad = 0, first = -1;
        for (int i = 0; i < MW; i++)
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, $sformatf("%s mem word %0d", tag, first), mem[first], ref_mem[first]);
    endtask

    task automatic drive(vec_t v);
        ctl_i = v.ctl[27:0]; dst_tl_i = v.dtl; dst_br_i = v.dbr; src_tl_i = v.stl;
        src_pitch_i = v.sp; dst_base_i = v.db; src_base_i = v.sb;
    endtask

    task automatic wait_done(inout int cyc);
        while (!done_o && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(20ns * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cyc, n;
        bit exp_err;
        for (int i = 0; i < MW; i++) ref_mem[i] = pat(i);
        repeat (3) @(negedge clk);
        // R8 reset state
        check(!busy_o, "R8 reset busy", busy_o, 0);
        check(!done_o, "R8 reset done", done_o, 0);
        check(!err_o, "R8 reset err", err_o, 0);
        check(!mem_req_o, "R8 reset mem_req", mem_req_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            exp_err = !ref_legal(VECS[i]);
            n = ref_pixels(VECS[i]);
            ref_apply(VECS[i]);
            drive(VECS[i]);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc = 1;
            wait_done(cyc);
            check(err_o == exp_err, $sformatf("R1 R7 vec %0d err", i), err_o, exp_err);
            check(cyc == 3 * n + 1, $sformatf("R3 R9 vec %0d done cycle", i), cyc, 3 * n + 1);
            @(negedge clk);
            check(!done_o && !busy_o, $sformatf("R8 vec %0d done pulse", i), done_o, 0);
            compare_mem($sformatf("R2 R4 R5 R6 R10 vec %0d", i));
        end

        // R5 R9: first access of a flipped copy is the source read at the start row
        ref_apply(VECS[5]);
        drive(VECS[5]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R8 busy after start", busy_o, 1);
        check(mem_req_o && !mem_we_o && mem_addr_o == 32'h3C0, "R5 R9 first source read",
              mem_addr_o, 32'h3C0);
        cyc = 1;
        wait_done(cyc);
        check(cyc == 3 * 12 + 1, "R9 flip done cycle", cyc, 37);
        compare_mem("R5 flip repeat");

        // R8: start and new inputs while busy are ignored
        ref_apply(VECS[1]);
        drive(VECS[1]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        drive(VECS[7]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 3;
        wait_done(cyc);
        check(cyc == 19, "R8 busy start ignored cycle", cyc, 19);
        repeat (4) @(negedge clk);
        check(!busy_o && !done_o, "R8 no second command", busy_o, 0);
        compare_mem("R8 busy start ignored mem");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule